// File: doc/BRIEF.md
# I2C Bus Condition Timing Generator

This block drives the clock and data lines of an I2C bus as a master. It produces START, repeated START and STOP conditions and the clocked bit slots between them. Both lines are open-drain, so the block only asserts active-low pull-down enables and never drives a line high. Every interval is a count of system clock cycles taken from a configuration input. One count is used for each condition interval: START hold, repeated-START setup, repeated-START hold, data setup, STOP setup and bus-free time. The SCL half period comes from a baud pre-scaler multiplied by a half-period divider. Software sets the divider to the system clock divided by twice the bus rate, and the pre-scaler is usually 1.

A byte-level engine sits beside the block and requests one bit slot at a time. It gets a pulse back when each slot finishes. Software, or the engine, raises one of three request pulses: start, stop or repeated start. A stop or repeated-start request that arrives during a bit slot is held and carried out once no bit slot is being requested. The busy output goes high with START. It stays high through STOP and the following bus-free interval, so a new START cannot be issued too early. One-cycle pulses report that a STOP or a repeated START has finished. A status register elsewhere can capture these pulses and clear them by writing 1.

Top module: `i2c_cond_timer`

## Requirements
- R1: After reset, scl_low and sda_low are 0, busy is 0, and bit_done, stop_done and rstart_done are 0.
- R2: A req_start pulse while busy is 0 makes busy 1 and drives sda_low=1 with scl_low=0 for max(cfg_start_hold,1) cycles. After that, scl_low becomes 1 and sda_low stays 1.
- R3: A bit_req pulse while the bus is held (scl_low=1 between slots) runs one slot. sda_low becomes the inverse of bit_val (1 = release, 0 = drive low). scl_low stays 1 for max(cfg_data_setup,1) cycles, then is 0 for one half period, then is 1 for one half period. bit_done then pulses for one cycle.
- R4: One SCL half period lasts max(cfg_prescale,1) × max(cfg_half_div,1) cycles.
- R5: A STOP drives sda_low=1 with scl_low=1 for max(cfg_data_setup,1) cycles. It then releases SCL for max(cfg_stop_setup,1) cycles with sda_low=1. Finally it releases SDA, and stop_done is 1 in the first cycle in which both lines are released.
- R6: After a STOP releases SDA, busy stays 1 for max(cfg_bus_free,1) cycles, counted from the stop_done cycle, and then returns to 0. A req_start during that interval is ignored.
- R7: A repeated START sets sda_low=0 with scl_low=1 for max(cfg_data_setup,1) cycles. It then releases SCL for max(cfg_rs_setup,1) cycles. It then drives sda_low=1 for max(cfg_rs_hold,1) cycles with SCL still released. After that, scl_low becomes 1 and rstart_done pulses in that first cycle.
- R8: A configured count of zero, including a zero pre-scaler or divider, behaves as one cycle.
- R9: req_stop and req_rstart have no effect while busy is 0. A pending stop or repeated start waits while bit_req is present. If both are pending, the STOP is carried out and the repeated start is dropped.
- R10: While SCL stays released across two cycles, SDA changes only as part of a START, repeated START or STOP.
- R11: scl_low is never 1 while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_prescale | input | PW | Baud pre-scaler count |
| cfg_half_div | input | CW | SCL half-period divider count |
| cfg_start_hold | input | CW | START hold cycles |
| cfg_rs_hold | input | CW | Repeated-START hold cycles |
| cfg_rs_setup | input | CW | Repeated-START setup cycles |
| cfg_data_setup | input | CW | Data setup cycles |
| cfg_stop_setup | input | CW | STOP setup cycles |
| cfg_bus_free | input | CW | Bus-free cycles after STOP |
| req_start | input | 1 | Start-generate request pulse |
| req_stop | input | 1 | Stop-generate request pulse |
| req_rstart | input | 1 | Repeated-start-generate request pulse |
| bit_req | input | 1 | Bit-slot strobe from the byte engine |
| bit_val | input | 1 | Bit value for the slot (1 = release SDA) |
| scl_low | output | 1 | Drive SCL low enable |
| sda_low | output | 1 | Drive SDA low enable |
| busy | output | 1 | Bus occupied, including bus-free time |
| bit_done | output | 1 | One-cycle pulse at end of a bit slot |
| stop_done | output | 1 | One-cycle pulse when STOP completes |
| rstart_done | output | 1 | One-cycle pulse when repeated START completes |

## Verification
The block is run with three timing sets: distinct nonzero counts, a second divider/pre-scaler split that gives a different product, and all counts at zero. Using distinct counts means each phase length identifies which configured count the block actually applied. The second split separates a correct product from a single operand. The all-zero set exercises the one-cycle minimum. Bit slots with both values show that SDA follows the bit and is set before SCL is released. Requests issued while idle, during bus-free time, and together with a bit strobe distinguish correct gating from early or lost conditions.

// File: rtl/i2c_cond_timer.sv
module i2c_cond_timer #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_prescale,
  input  logic [CW-1:0] cfg_half_div,
  input  logic [CW-1:0] cfg_start_hold,
  input  logic [CW-1:0] cfg_rs_hold,
  input  logic [CW-1:0] cfg_rs_setup,
  input  logic [CW-1:0] cfg_data_setup,
  input  logic [CW-1:0] cfg_stop_setup,
  input  logic [CW-1:0] cfg_bus_free,
  input  logic          req_start,
  input  logic          req_stop,
  input  logic          req_rstart,
  input  logic          bit_req,
  input  logic          bit_val,
  output logic          scl_low,
  output logic          sda_low,
  output logic          busy,
  output logic          bit_done,
  output logic          stop_done,
  output logic          rstart_done
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_SHOLD, ST_WAIT, ST_DSET, ST_HIGH, ST_LOW,
    ST_PSET, ST_PHI, ST_FREE, ST_RSET, ST_RHI, ST_RHOLD
  } state_t;

  state_t        state, nxt;
  logic [CW-1:0] cnt, tgt, tgt_m1;
  logic [PW-1:0] pcnt, pre_m1;
  logic          sda_q, pend_stop, pend_rs;
  logic          baud, pwrap, done, owned;
  logic          stop_want, rs_want;

  assign baud   = (state == ST_HIGH) || (state == ST_LOW);
  assign owned  = (state != ST_IDLE) && (state != ST_FREE);
  assign pre_m1 = (cfg_prescale == '0) ? '0 : cfg_prescale - PW'(1);
  assign tgt_m1 = (tgt == '0) ? '0 : tgt - CW'(1);
  assign pwrap  = (pcnt == pre_m1);
  assign done   = (cnt == tgt_m1) && (!baud || pwrap);

  assign stop_want = pend_stop | req_stop;
  assign rs_want   = pend_rs | req_rstart;

  always_comb begin
    case (state)
      ST_SHOLD:                 tgt = cfg_start_hold;
      ST_DSET, ST_PSET, ST_RSET: tgt = cfg_data_setup;
      ST_HIGH, ST_LOW:          tgt = cfg_half_div;
      ST_PHI:                   tgt = cfg_stop_setup;
      ST_FREE:                  tgt = cfg_bus_free;
      ST_RHI:                   tgt = cfg_rs_setup;
      ST_RHOLD:                 tgt = cfg_rs_hold;
      default:                  tgt = '0;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (req_start) nxt = ST_SHOLD;
      ST_SHOLD: if (done) nxt = ST_WAIT;
      ST_WAIT: begin
        if (bit_req)        nxt = ST_DSET;
        else if (stop_want) nxt = ST_PSET;
        else if (rs_want)   nxt = ST_RSET;
      end
      ST_DSET:  if (done) nxt = ST_HIGH;
      ST_HIGH:  if (done) nxt = ST_LOW;
      ST_LOW:   if (done) nxt = ST_WAIT;
      ST_PSET:  if (done) nxt = ST_PHI;
      ST_PHI:   if (done) nxt = ST_FREE;
      ST_FREE:  if (done) nxt = ST_IDLE;
      ST_RSET:  if (done) nxt = ST_RHI;
      ST_RHI:   if (done) nxt = ST_RHOLD;
      ST_RHOLD: if (done) nxt = ST_WAIT;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pcnt  <= '0;
    end else begin
      state <= nxt;
      if (nxt != state) begin
        cnt  <= '0;
        pcnt <= '0;
      end else if (baud) begin
        pcnt <= pwrap ? '0 : pcnt + PW'(1);
        if (pwrap) cnt <= cnt + CW'(1);
      end else if (state != ST_IDLE && state != ST_WAIT) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b0;
    end else if (nxt != state) begin
      case (nxt)
        ST_SHOLD, ST_PSET, ST_RHOLD: sda_q <= 1'b1;
        ST_DSET:                     sda_q <= ~bit_val;
        ST_FREE, ST_RSET:            sda_q <= 1'b0;
        default:                     sda_q <= sda_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_stop <= 1'b0;
      pend_rs   <= 1'b0;
    end else if (nxt == ST_PSET && state == ST_WAIT) begin
      pend_stop <= 1'b0;
      pend_rs   <= 1'b0;
    end else begin
      if (req_stop && owned) pend_stop <= 1'b1;
      if (nxt == ST_RSET && state == ST_WAIT) pend_rs <= 1'b0;
      else if (req_rstart && owned)           pend_rs <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_done    <= 1'b0;
      stop_done   <= 1'b0;
      rstart_done <= 1'b0;
    end else begin
      bit_done    <= (state == ST_LOW)   && (nxt == ST_WAIT);
      stop_done   <= (state == ST_PHI)   && (nxt == ST_FREE);
      rstart_done <= (state == ST_RHOLD) && (nxt == ST_WAIT);
    end
  end

  assign busy    = (state != ST_IDLE);
  assign sda_low = sda_q;
  assign scl_low = (state == ST_WAIT) || (state == ST_DSET) || (state == ST_LOW) ||
                   (state == ST_PSET) || (state == ST_RSET);

  p_scl_owned_r11: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low |-> busy);

  p_start_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sda_low && !scl_low));

  p_free_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |-> (busy && !sda_low && !scl_low));

  p_rs_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_done |-> (scl_low && sda_low && $past(!scl_low && sda_low)));

  p_pulse_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_done && rstart_done));

  p_sda_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_low && $past(!scl_low) && (sda_low != $past(sda_low))) |->
      (state == ST_SHOLD || state == ST_FREE || state == ST_RHOLD));

endmodule

// File: tb/test_i2c_cond_timer.sv
`timescale 1ns/1ps
module test_i2c_cond_timer;
  localparam int CW = 16;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] cfg_prescale = '0;
  logic [CW-1:0] cfg_half_div = '0, cfg_start_hold = '0, cfg_rs_hold = '0;
  logic [CW-1:0] cfg_rs_setup = '0, cfg_data_setup = '0, cfg_stop_setup = '0, cfg_bus_free = '0;
  logic          req_start = 1'b0, req_stop = 1'b0, req_rstart = 1'b0;
  logic          bit_req = 1'b0, bit_val = 1'b0;
  logic          scl_low, sda_low, busy, bit_done, stop_done, rstart_done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  i2c_cond_timer #(.CW(CW), .PW(PW)) i_i2c_cond_timer (
    .clk(clk), .rst_n(rst_n),
    .cfg_prescale(cfg_prescale), .cfg_half_div(cfg_half_div),
    .cfg_start_hold(cfg_start_hold), .cfg_rs_hold(cfg_rs_hold),
    .cfg_rs_setup(cfg_rs_setup), .cfg_data_setup(cfg_data_setup),
    .cfg_stop_setup(cfg_stop_setup), .cfg_bus_free(cfg_bus_free),
    .req_start(req_start), .req_stop(req_stop), .req_rstart(req_rstart),
    .bit_req(bit_req), .bit_val(bit_val),
    .scl_low(scl_low), .sda_low(sda_low), .busy(busy),
    .bit_done(bit_done), .stop_done(stop_done), .rstart_done(rstart_done)
  );

  int e_sh, e_ds, e_half, e_ps, e_bf, e_rsu, e_rh;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setcfg(input int pre, input int div, input int sh, input int rh,
                        input int rsu, input int ds, input int ps, input int bf);
    cfg_prescale = PW'(pre); cfg_half_div = CW'(div); cfg_start_hold = CW'(sh);
    cfg_rs_hold = CW'(rh); cfg_rs_setup = CW'(rsu); cfg_data_setup = CW'(ds);
    cfg_stop_setup = CW'(ps); cfg_bus_free = CW'(bf);
    e_sh = eff(sh); e_ds = eff(ds); e_half = eff(pre) * eff(div);
    e_ps = eff(ps); e_bf = eff(bf); e_rsu = eff(rsu); e_rh = eff(rh);
  endtask

  task automatic run_len(input bit s, input bit d, input bit need_busy, output int n);
    n = 0;
    while (scl_low == s && sda_low == d && (!need_busy || busy) && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(!scl_low && !sda_low && !busy, "R1 lines/busy", {scl_low, sda_low, busy}, 0);
    chk(!bit_done && !stop_done && !rstart_done, "R1 pulses",
        {bit_done, stop_done, rstart_done}, 0);
  endtask

  task automatic t_start;
    int n;
    req_start = 1'b1; @(negedge clk); req_start = 1'b0;
    chk(busy, "R2 busy rises", busy, 1);
    run_len(1'b0, 1'b1, 1'b0, n);
    chk(n == e_sh, "R2 start hold", n, e_sh);
    chk(scl_low && sda_low, "R2 scl low after hold", {scl_low, sda_low}, 3);
  endtask

  task automatic t_bit(input bit v, input string tag);
    int n;
    bit_req = 1'b1; bit_val = v; @(negedge clk); bit_req = 1'b0;
    run_len(1'b1, !v, 1'b0, n);
    chk(n == e_ds, {tag, " R3 data setup"}, n, e_ds);
    run_len(1'b0, !v, 1'b0, n);
    chk(n == e_half, {tag, " R4 scl high"}, n, e_half);
    n = 0;
    while (scl_low && !bit_done && n < 5000) begin n++; @(negedge clk); end
    chk(n == e_half, {tag, " R4 scl low"}, n, e_half);
    chk(bit_done && scl_low && (sda_low == !v), {tag, " R3 bit_done"}, bit_done, 1);
  endtask

  task automatic stop_body(input bool_check_start_in_free);
    int n;
    run_len(1'b1, 1'b1, 1'b0, n);
    chk(n == e_ds, "R5 stop data setup", n, e_ds);
    run_len(1'b0, 1'b1, 1'b0, n);
    chk(n == e_ps, "R5 stop setup", n, e_ps);
    chk(stop_done && !sda_low && !scl_low, "R5 stop_done", stop_done, 1);
    if (bool_check_start_in_free) begin
      req_start = 1'b1; @(negedge clk); req_start = 1'b0;
      run_len(1'b0, 1'b0, 1'b1, n);
      chk(n == e_bf - 1, "R6 bus free with start", n + 1, e_bf);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (busy || scl_low || sda_low) n = -1;
      end
      chk(n != -1, "R6 start in bus free ignored", n, e_bf - 1);
    end else begin
      run_len(1'b0, 1'b0, 1'b1, n);
      chk(n == e_bf, "R6 bus free", n, e_bf);
    end
    chk(!busy, "R6 busy drops", busy, 0);
  endtask

  task automatic t_stop(input bit start_in_free);
    req_stop = 1'b1; @(negedge clk); req_stop = 1'b0;
    stop_body(start_in_free);
  endtask

  task automatic t_rstart;
    int n;
    req_rstart = 1'b1; @(negedge clk); req_rstart = 1'b0;
    run_len(1'b1, 1'b0, 1'b0, n);
    chk(n == e_ds, "R7 rs data setup", n, e_ds);
    run_len(1'b0, 1'b0, 1'b0, n);
    chk(n == e_rsu, "R7 rs setup", n, e_rsu);
    run_len(1'b0, 1'b1, 1'b0, n);
    chk(n == e_rh, "R7 rs hold", n, e_rh);
    chk(rstart_done && scl_low && sda_low, "R7 rstart_done", rstart_done, 1);
  endtask

  task automatic t_idle_ignore;
    int bad = 0;
    req_stop = 1'b1; req_rstart = 1'b1; @(negedge clk);
    req_stop = 1'b0; req_rstart = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (busy || scl_low || sda_low || stop_done || rstart_done) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 idle requests ignored", bad, 0);
    t_start();
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!(scl_low && sda_low && busy) || stop_done || rstart_done) bad++;
    end
    chk(bad == 0, "R9 no stale request after start", bad, 0);
  endtask

  task automatic t_priority;
    req_stop = 1'b1; req_rstart = 1'b1; bit_req = 1'b1; bit_val = 1'b1;
    @(negedge clk);
    req_stop = 1'b0; req_rstart = 1'b0; bit_req = 1'b0;
    begin
      int n;
      run_len(1'b1, 1'b0, 1'b0, n);
      chk(n == e_ds, "R9 bit before pending stop", n, e_ds);
      run_len(1'b0, 1'b0, 1'b0, n);
      n = 0;
      while (scl_low && !bit_done && n < 5000) begin n++; @(negedge clk); end
      chk(bit_done, "R9 bit completes first", bit_done, 1);
    end
    @(negedge clk);
    stop_body(1'b0);
    begin
      int bad = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (busy || rstart_done) bad++;
      end
      chk(bad == 0, "R9 repeated start dropped after stop", bad, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    setcfg(2, 3, 5, 4, 6, 2, 7, 9);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_bit(1'b0, "b0");
    t_bit(1'b1, "b1");
    t_rstart();
    t_bit(1'b1, "b1 after rs");
    t_stop(1'b0);
    setcfg(1, 5, 3, 2, 4, 3, 5, 6);
    t_start();
    t_bit(1'b1, "alt div");
    t_bit(1'b0, "alt div");
    t_stop(1'b1);
    setcfg(0, 0, 0, 0, 0, 0, 0, 0);
    t_start();
    t_bit(1'b0, "R8 zero");
    t_rstart();
    t_stop(1'b0);
    setcfg(2, 3, 5, 4, 6, 2, 7, 9);
    t_idle_ignore();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule